// File: doc/BRIEF.md
# GPIO Edge Interrupt Controller

This block monitors a bank of general-purpose input pins and signals an interrupt when a chosen transition appears on a pin that software has enabled. Each pin has its own two-bit code that selects no edge, rising, falling or both. Software reaches a small register file through a read/write strobe port. Through it, software can read the synchronized pin levels and program the enable mask and the sense codes. It can also see which pins raised the interrupt and which pins saw any selected edge, and it can acknowledge events.

The interrupt pin is open-drain and active-low. The block does not model a tri-state pad. Instead it provides an output-enable: when `irq_oe` is high, the pad pulls the line low. An optional configuration bit makes a read of the pin-level register also acknowledge every pending event. This lets a handler that only samples the pins skip the separate acknowledge write.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset the mask register (address 1) reads 0xFF, the source (address 4), event (address 5), configuration (address 6) and both sense registers (addresses 2 and 3) read 0, and `irq_oe` is 0.
- R2: Each pin passes through two synchronizing flops. A level applied before clock edge k appears in the pin-level register (address 0, bit i = pin i) after edge k+1, and an edge it forms is recorded at edge k+2.
- R3: Pin i's sense code sits at bits [2i+1:2i] of the 16-bit value {address 2, address 3}, so address 3 holds pins 0..3 and address 2 holds pins 4..7. The codes are: 00 detects nothing, 01 detects a 0→1 change, 10 detects a 1→0 change, and 11 detects both.
- R4: A mask bit of 0 enables its pin. A selected edge on an enabled pin sets that pin's bit in the source register, and an edge on a masked pin never sets it. `irq_oe` is 1 exactly while any source bit is set.
- R5: The event register (address 5) records every selected edge, whatever the mask.
- R6: Writing the source register clears each source bit written as 1, along with the matching event bit. Bits written as 0 keep their value.
- R7: With configuration bit 0 (address 6) set, a read strobe at address 0 clears all source and event bits. With the bit clear, such a read changes nothing.
- R8: An edge recorded in the same cycle as a clear of its bit leaves the bit set.
- R9: Writes to addresses 0 and 5 are ignored. The mask changes only through a write to address 1. Address 7 reads 0. Configuration bits other than bit 0 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 8 | Asynchronous GPIO pin levels |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe, acts at the clock edge |
| reg_rd | input | 1 | Read strobe, used only for the auto-clear side effect |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| irq_oe | output | 1 | Drive the open-drain interrupt line low when 1 |

## Verification
A wrong synchronizer or previous-value register makes edges appear one cycle early or late. A wrong sense decode records the wrong direction. Either fault shows on `irq_oe` and the source and event registers in the cycle the edge is due. A reference model steps alongside the design and compares `irq_oe` and the addressed read data after every clock, so a corrupted mask, sense, source or event bit becomes visible within one cycle of being read or of the edge it affects. Directed sequences aim at the bit-level acknowledge, the auto-clear read and an edge that lands in the same cycle as its own clear.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int REG_AW = 3;

    typedef enum logic [1:0] {
        SENSE_NONE = 2'b00,
        SENSE_RISE = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_BOTH = 2'b11
    } sense_e;

    typedef enum logic [REG_AW-1:0] {
        A_LEVEL   = 3'd0,
        A_MASK    = 3'd1,
        A_SENSE_H = 3'd2,
        A_SENSE_L = 3'd3,
        A_SRC     = 3'd4,
        A_EVT     = 3'd5,
        A_CFG     = 3'd6,
        A_NONE    = 3'd7
    } addr_e;

    typedef struct packed {
        logic  wr;
        logic  rd;
        addr_e addr;
    } bus_req_t;

    function automatic logic edge_hit(sense_e code, logic now_v, logic was_v);
        case (code)
            SENSE_RISE: return now_v & ~was_v;
            SENSE_FALL: return ~now_v & was_v;
            SENSE_BOTH: return now_v ^ was_v;
            default:    return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det
    import gpio_irq_pkg::*;
#(
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [N-1:0]   level,
    input  logic [2*N-1:0] sense,
    output logic [N-1:0]   hit
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= level;
    end

    for (genvar g = 0; g < N; g++) begin : g_pin
        assign hit[g] = edge_hit(sense_e'(sense[2*g +: 2]), level[g], prev_q[g]);
    end
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  bus_req_t       req,
    input  logic [N-1:0]   wdata,
    input  logic [N-1:0]   level,
    input  logic [N-1:0]   hit,
    output logic [2*N-1:0] sense,
    output logic [N-1:0]   rdata,
    output logic           irq
);
    logic [N-1:0]   mask_q;
    logic [2*N-1:0] sense_q;
    logic [N-1:0]   src_q;
    logic [N-1:0]   evt_q;
    logic           autoclr_q;
    logic [N-1:0]   clr;

    always_comb begin
        clr = '0;
        if (req.wr && req.addr == A_SRC)
            clr = clr | wdata;
        if (req.rd && req.addr == A_LEVEL && autoclr_q)
            clr = '1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q    <= '1;
            sense_q   <= '0;
            src_q     <= '0;
            evt_q     <= '0;
            autoclr_q <= 1'b0;
        end else begin
            src_q <= (src_q & ~clr) | (hit & ~mask_q);
            evt_q <= (evt_q & ~clr) | hit;
            if (req.wr) begin
                case (req.addr)
                    A_MASK:    mask_q          <= wdata;
                    A_SENSE_L: sense_q[N-1:0]  <= wdata;
                    A_SENSE_H: sense_q[2*N-1:N] <= wdata;
                    A_CFG:     autoclr_q       <= wdata[0];
                    default:   ;
                endcase
            end
        end
    end

    always_comb begin
        case (req.addr)
            A_LEVEL:   rdata = level;
            A_MASK:    rdata = mask_q;
            A_SENSE_H: rdata = sense_q[2*N-1:N];
            A_SENSE_L: rdata = sense_q[N-1:0];
            A_SRC:     rdata = src_q;
            A_EVT:     rdata = evt_q;
            A_CFG:     rdata = {{(N-1){1'b0}}, autoclr_q};
            default:   rdata = '0;
        endcase
    end

    assign sense = sense_q;
    assign irq   = |src_q;
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
    import gpio_irq_pkg::*;
#(
    parameter int N = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N-1:0]      pin_in,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [N-1:0]      reg_wdata,
    output logic [N-1:0]      reg_rdata,
    output logic              irq_oe
);
    logic [N-1:0]   level;
    logic [N-1:0]   hit;
    logic [2*N-1:0] sense;
    bus_req_t       req;

    assign req.wr   = reg_wr;
    assign req.rd   = reg_rd;
    assign req.addr = addr_e'(reg_addr);

    gpio_sync #(.W(N)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pin_in),
        .sync_out (level)
    );

    gpio_edge_det #(.N(N)) u_edge (
        .clk   (clk),
        .rst   (rst),
        .level (level),
        .sense (sense),
        .hit   (hit)
    );

    gpio_irq_regs #(.N(N)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .wdata (reg_wdata),
        .level (level),
        .hit   (hit),
        .sense (sense),
        .rdata (reg_rdata),
        .irq   (irq_oe)
    );
endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [2:0]   reg_addr,
    input logic         reg_wr,
    input logic         reg_rd,
    input logic         irq_oe,
    input logic [N-1:0] mask,
    input logic [N-1:0] src,
    input logic [N-1:0] evt,
    input logic         autoclr
);
    // R1
    reset_val_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask == '1 && src == '0 && evt == '0 && !autoclr && !irq_oe));

    // R4
    masked_src_chk: assert property (@(posedge clk) disable iff (rst)
        ((src & ~$past(src) & $past(mask)) == '0));

    // R5
    src_in_evt_chk: assert property (@(posedge clk) disable iff (rst)
        ((src & ~evt) == '0));

    // R6
    irq_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_oe) |-> ($past(reg_wr && reg_addr == 3'd4) ||
                           $past(reg_rd && reg_addr == 3'd0 && autoclr)));

    // R9
    mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(reg_wr && reg_addr == 3'd1) |-> $stable(mask));
endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(.N(N)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .reg_addr (reg_addr),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .irq_oe   (irq_oe),
    .mask     (u_regs.mask_q),
    .src      (u_regs.src_q),
    .evt      (u_regs.evt_q),
    .autoclr  (u_regs.autoclr_q)
);

// File: tb/tb_gpio_edge_irq.sv
module tb_gpio_edge_irq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] pin = 8'h00;
    logic [2:0] addr = 3'd0;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    gpio_edge_irq dut (
        .clk(clk), .rst(rst), .pin_in(pin), .reg_addr(addr),
        .reg_wr(wr), .reg_rd(rd), .reg_wdata(wdata),
        .reg_rdata(rdata), .irq_oe(irq_oe)
    );

    // behavioural reference model
    logic [7:0]  m_s1, m_s2, m_prev, m_mask, m_src, m_evt;
    logic [15:0] m_sense;
    logic        m_cfg;

    always @(posedge clk) begin
        logic [7:0] h, c;
        if (rst) begin
            m_s1 = 0; m_s2 = 0; m_prev = 0; m_mask = 8'hFF;
            m_src = 0; m_evt = 0; m_sense = 0; m_cfg = 0;
        end else begin
            h = 0;
            for (int i = 0; i < 8; i++) begin
                int code;
                code = int'(m_sense[2*i +: 2]);
                if (code == 1) h[i] = m_s2[i] && !m_prev[i];
                if (code == 2) h[i] = !m_s2[i] && m_prev[i];
                if (code == 3) h[i] = m_s2[i] != m_prev[i];
            end
            c = 0;
            if (wr && addr == 4) c = wdata;
            if (rd && addr == 0 && m_cfg) c = 8'hFF;
            m_src = (m_src & ~c) | (h & ~m_mask);
            m_evt = (m_evt & ~c) | h;
            if (wr) begin
                if (addr == 1) m_mask = wdata;
                if (addr == 2) m_sense[15:8] = wdata;
                if (addr == 3) m_sense[7:0] = wdata;
                if (addr == 6) m_cfg = wdata[0];
            end
            m_prev = m_s2; m_s2 = m_s1; m_s1 = pin;
        end
    end

    function automatic logic [7:0] model_rd(logic [2:0] a);
        case (a)
            3'd0: return m_s2;
            3'd1: return m_mask;
            3'd2: return m_sense[15:8];
            3'd3: return m_sense[7:0];
            3'd4: return m_src;
            3'd5: return m_evt;
            3'd6: return {7'd0, m_cfg};
            default: return 8'h00;
        endcase
    endfunction

    function automatic string tag_of(logic [2:0] a);
        case (a)
            3'd0: return "R2";
            3'd2, 3'd3: return "R3";
            3'd4: return "R4";
            3'd5: return "R5";
            default: return "R9";
        endcase
    endfunction

    task automatic check(string req, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h t=%0t", req, got, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        #5;
        if (!rst && !done) begin
            check("R4", {7'd0, irq_oe}, {7'd0, |m_src});
            check(tag_of(addr), rdata, model_rd(addr));
        end
    end

    task automatic wreg(logic [2:0] a, logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic rreg(logic [2:0] a, logic [7:0] exp, string req);
        @(negedge clk); addr = a; #2;
        check(req, rdata, exp);
    endtask

    task automatic drive(logic [7:0] v);
        @(negedge clk); pin = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic rd_pulse();
        @(negedge clk); addr = 3'd0; rd = 1'b1;
        @(negedge clk); rd = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rreg(3'd1, 8'hFF, "R1");
        rreg(3'd4, 8'h00, "R1");
        rreg(3'd5, 8'h00, "R1");
        rreg(3'd6, 8'h00, "R1");
        rreg(3'd3, 8'h00, "R1");
        rreg(3'd2, 8'h00, "R1");
        check("R1", {7'd0, irq_oe}, 8'h00);

        // pin1 rising, enabled
        wreg(3'd3, 8'h04);
        wreg(3'd1, 8'hFD);
        @(negedge clk); addr = 3'd0; pin = 8'h02;
        @(negedge clk); #2 check("R2", rdata, 8'h00);
        @(negedge clk); #2 check("R2", rdata, 8'h02);
        @(negedge clk); #2 check("R4", {7'd0, irq_oe}, 8'h01);
        rreg(3'd4, 8'h02, "R4");
        rreg(3'd5, 8'h02, "R5");

        // R6 bitwise acknowledge
        wreg(3'd4, 8'h00);
        rreg(3'd4, 8'h02, "R6");
        wreg(3'd4, 8'hFD);
        rreg(3'd4, 8'h02, "R6");
        wreg(3'd4, 8'h02);
        rreg(3'd4, 8'h00, "R6");
        rreg(3'd5, 8'h00, "R6");
        check("R6", {7'd0, irq_oe}, 8'h00);

        // R3 falling edge with rise code
        drive(8'h00);
        rreg(3'd5, 8'h00, "R3");

        // R5 masked pin still recorded
        wreg(3'd3, 8'h14);
        drive(8'h04);
        rreg(3'd5, 8'h04, "R5");
        rreg(3'd4, 8'h00, "R4");
        wreg(3'd4, 8'hFF);

        // R3 falling / both on upper pins
        wreg(3'd2, 8'h38);
        wreg(3'd1, 8'h9F);
        drive(8'h24);
        rreg(3'd4, 8'h00, "R3");
        drive(8'h04);
        rreg(3'd4, 8'h20, "R3");
        wreg(3'd4, 8'hFF);
        drive(8'h44);
        rreg(3'd4, 8'h40, "R3");
        wreg(3'd4, 8'hFF);
        drive(8'h04);
        rreg(3'd4, 8'h40, "R3");
        wreg(3'd4, 8'hFF);

        // R7 auto clear on level read
        wreg(3'd6, 8'hFF);
        rreg(3'd6, 8'h01, "R9");
        drive(8'h44);
        rd_pulse();
        #2 check("R7", {7'd0, irq_oe}, 8'h00);
        rreg(3'd4, 8'h00, "R7");
        rreg(3'd5, 8'h00, "R7");
        wreg(3'd6, 8'h00);
        drive(8'h04);
        rd_pulse();
        rreg(3'd4, 8'h40, "R7");
        wreg(3'd4, 8'hFF);

        // R8 edge in the same cycle as its clear
        @(negedge clk); pin = 8'h44;
        @(negedge clk);
        @(negedge clk); addr = 3'd4; wdata = 8'hFF; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
        rreg(3'd4, 8'h40, "R8");
        rreg(3'd5, 8'h40, "R8");

        // R9 ignored writes and unused address
        wreg(3'd5, 8'h00);
        rreg(3'd5, 8'h40, "R9");
        wreg(3'd0, 8'hFF);
        rreg(3'd0, 8'h44, "R9");
        rreg(3'd7, 8'h00, "R9");
        rreg(3'd1, 8'h9F, "R9");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule